// File: doc/BRIEF.md
# Plane Saturation Monitor and Decay Engine

This block sits beside an accumulator that adds patterns into a 256×256 image plane of 8-bit darkness cells. The plane is stored as 64-bit words that hold eight cells each. While an accumulation runs, the block listens to every word the accumulator writes. If any cell value in such a write is above a threshold that the host picks, the block records it in a sticky flag. The accumulation is never interrupted by this.

When the accumulator reports that its operation has ended and the flag is set, the block takes over the plane memory port and sweeps the whole plane. It visits the words in ascending order, reading each one and writing it back with every cell halved. This frees headroom so that later additions do not wrap. The sweep waits on a single grant line from the memory arbiter. A busy output tells the accumulator that it must not start a new operation until the sweep is finished.

Top module: `plane_decay_unit`

## Requirements
- R1: After reset, `busy`, `exceedFlag` and `memReq` are all 0.
- R2: A snooped write (`snoopWrEn`=1 while idle) sets `exceedFlag` from the next cycle if any byte lane `snoopWrData[8i+7:8i]` (i = 0..7) is strictly greater than the threshold. A lane equal to the threshold does not set the flag.
- R3: `thrSel`=0 selects threshold 0xE0 and `thrSel`=1 selects threshold 0xF0.
- R4: Once set, `exceedFlag` stays set through later non-exceeding snooped writes until a sweep completes.
- R5: `accumDone` starts a sweep when the flag is set or when a write in that same cycle exceeds the threshold. `busy` then rises in the next cycle. `accumDone` with no exceed leaves the block idle, with `busy`=0 and `memReq`=0.
- R6: A sweep covers every word from address 0 to address 2^ADDR_W-1 exactly once, in ascending order. At each address it issues a read (`memWe`=0) before the write (`memWe`=1).
- R7: The word written back equals the word read with each byte lane logically shifted right by one bit.
- R8: A request that is not granted stays asserted, with the same address and the same direction, until `memGrant` is 1. A transfer takes place in a cycle where `memReq` and `memGrant` are both 1. Read data is taken in the cycle where `memRvalid` is 1.
- R9: When the last write of a sweep is granted, `busy` and `exceedFlag` are both 0 from the next cycle.
- R10: While `busy` is 1, snooped writes and `accumDone` have no effect. After the sweep the flag is 0 and no second sweep follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrSel | input | 1 | Threshold choice: 0 selects 0xE0, 1 selects 0xF0 |
| snoopWrEn | input | 1 | Accumulator is writing a plane word this cycle |
| snoopWrData | input | 64 | Word being written by the accumulator |
| accumDone | input | 1 | One-cycle pulse at the end of an accumulation |
| memReq | output | 1 | Sweep request to the plane memory |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word address of the request |
| memWdata | output | 64 | Halved word for a write |
| memGrant | input | 1 | Arbiter accepts the current request |
| memRdata | input | 64 | Read data |
| memRvalid | input | 1 | Read data is valid, at least one cycle after the read grant |
| busy | output | 1 | Sweep in progress |
| exceedFlag | output | 1 | Sticky threshold-crossing indicator |

## Verification
The hardest situation to reach from the ports is a sweep that is already running when the accumulator writes a saturating word or pulses `accumDone` again. Such events would wrongly set the flag or trigger a second sweep. The bench injects both while `busy` is high. It then confirms that the flag comes out clear and that no further memory requests follow. All sweeps run under a pseudo-random grant pattern, so that held requests and stalled addresses are exercised. The threshold boundaries are hit exactly, at 0xE0 and 0xE1 for `thrSel`=0 and at 0xF0 and 0xF1 for `thrSel`=1. The crossings are placed in single, differing byte lanes.

// File: rtl/pdu_pkg.sv
package pdu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2,
    ST_WR   = 2'd3
  } sweepState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic snoopArm;  // snooped writes may set the flag
    logic flagClr;   // sweep finished, drop the flag
    logic addrClr;   // restart sweep address at zero
    logic addrInc;   // advance to next word
    logic dataCap;   // capture read word, halved
  } pduCtrl_t;

endpackage

// File: rtl/pdu_datapath.sv
module pdu_datapath
  import pdu_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned THR_LO = 224,
  parameter int unsigned THR_HI = 240,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  pduCtrl_t          ctrl,
  input  logic              thrSel,
  input  logic              snoopWrEn,
  input  logic [DATA_W-1:0] snoopWrData,
  input  logic [DATA_W-1:0] rdData,
  output logic              hitNow,
  output logic              exceedFlag,
  output logic [ADDR_W-1:0] addr,
  output logic              lastAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam logic [LANE_W-1:0] THR_LO_V = LANE_W'(THR_LO);
  localparam logic [LANE_W-1:0] THR_HI_V = LANE_W'(THR_HI);
  localparam logic [LANE_W-1:0] LANE_MSB = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MSB_MASK = {LANES{LANE_MSB}};

  logic [LANE_W-1:0] thrVal;
  logic [LANES-1:0]  laneHit;
  logic [DATA_W-1:0] halved;

  assign thrVal = thrSel ? THR_HI_V : THR_LO_V;

  // Per-lane strict comparison
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneHit[g] = snoopWrData[g*LANE_W +: LANE_W] > thrVal;
  end

  assign hitNow = snoopWrEn && ctrl.snoopArm && (|laneHit);

  // Shift whole word and clear each lane's top bit: per-lane halving
  assign halved = (rdData >> 1) & ~MSB_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exceedFlag <= 1'b0;
    end else if (ctrl.flagClr) begin
      exceedFlag <= 1'b0;
    end else if (hitNow) begin
      exceedFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (ctrl.addrClr) begin
      addr <= '0;
    end else if (ctrl.addrInc) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrData <= '0;
    end else if (ctrl.dataCap) begin
      wrData <= halved;
    end
  end

  assign lastAddr = &addr;

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hitNow && !ctrl.flagClr) |=> exceedFlag);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (exceedFlag && !ctrl.flagClr) |=> exceedFlag);

endmodule

// File: rtl/pdu_control.sv
module pdu_control
  import pdu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     accumDone,
  input  logic     hitNow,
  input  logic     exceedFlag,
  input  logic     lastAddr,
  input  logic     memGrant,
  input  logic     memRvalid,
  output pduCtrl_t ctrl,
  output logic     memReq,
  output logic     memWe,
  output logic     busy
);

  sweepState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      ST_IDLE: begin
        ctrl.snoopArm = 1'b1;
        if (accumDone && (exceedFlag || hitNow)) begin
          ctrl.addrClr = 1'b1;
          stateNext    = ST_RD;
        end
      end
      ST_RD: begin
        memReq = 1'b1;
        if (memGrant) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRvalid) begin
          ctrl.dataCap = 1'b1;
          stateNext    = ST_WR;
        end
      end
      ST_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memGrant) begin
          if (lastAddr) begin
            ctrl.flagClr = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            ctrl.addrInc = 1'b1;
            stateNext    = ST_RD;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  p_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && accumDone && exceedFlag) |=> busy);

  p_no_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && accumDone && !exceedFlag && !hitNow) |=> !busy);

  p_wait_after_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGrant && !memWe) |=> (busy && !memReq));

endmodule

// File: rtl/plane_decay_unit.sv
module plane_decay_unit
  import pdu_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned THR_LO = 224,
  parameter int unsigned THR_HI = 240,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              thrSel,
  input  logic              snoopWrEn,
  input  logic [DATA_W-1:0] snoopWrData,
  input  logic              accumDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memGrant,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memRvalid,
  output logic              busy,
  output logic              exceedFlag
);

  localparam logic [LANE_W-1:0] LANE_MSB = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MSB_MASK = {LANES{LANE_MSB}};

  pduCtrl_t ctrl;
  logic     hitNow;
  logic     lastAddr;

  pdu_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .accumDone  (accumDone),
    .hitNow     (hitNow),
    .exceedFlag (exceedFlag),
    .lastAddr   (lastAddr),
    .memGrant   (memGrant),
    .memRvalid  (memRvalid),
    .ctrl       (ctrl),
    .memReq     (memReq),
    .memWe      (memWe),
    .busy       (busy)
  );

  pdu_datapath #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .ADDR_W (ADDR_W),
    .THR_LO (THR_LO),
    .THR_HI (THR_HI)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .thrSel      (thrSel),
    .snoopWrEn   (snoopWrEn),
    .snoopWrData (snoopWrData),
    .rdData      (memRdata),
    .hitNow      (hitNow),
    .exceedFlag  (exceedFlag),
    .addr        (memAddr),
    .lastAddr    (lastAddr),
    .wrData      (memWdata)
  );

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGrant) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  p_halved_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> ((memWdata & MSB_MASK) == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !exceedFlag);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: tb/plane_decay_unit_test.sv
module plane_decay_unit_test;

  localparam int unsigned AW    = 5;
  localparam int unsigned WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          thrSel = 1'b0;
  logic          snoopWrEn = 1'b0;
  logic [63:0]   snoopWrData = '0;
  logic          accumDone = 1'b0;
  logic          memReq, memWe, memGrant, memRvalid;
  logic [AW-1:0] memAddr;
  logic [63:0]   memWdata, memRdata;
  logic          busy, exceedFlag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  plane_decay_unit #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .thrSel(thrSel),
    .snoopWrEn(snoopWrEn), .snoopWrData(snoopWrData), .accumDone(accumDone),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memGrant(memGrant), .memRdata(memRdata), .memRvalid(memRvalid),
    .busy(busy), .exceedFlag(exceedFlag)
  );

  // ---------------- memory model and arbiter ----------------
  logic [63:0] mem [WORDS];
  logic [7:0]  lfsr = 8'hA5;
  logic        fullGrant = 1'b0;
  logic        loadPulse = 1'b0;
  logic [7:0]  loadSeed = '0;

  function automatic logic [63:0] pattern(int idx, logic [7:0] seed);
    logic [63:0] v;
    v = 64'hF1E2_D3C4_B5A6_9788 ^ ({8{8'(idx)}} * {56'd0, seed}) ^ {8{seed}};
    return v;
  endfunction

  function automatic logic [63:0] halve(logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = d[i*8 +: 8] / 2;
    return r;
  endfunction

  assign memGrant = fullGrant | lfsr[0];

  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memRvalid <= 1'b0;
    if (loadPulse) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= pattern(i, loadSeed);
    end else if (memReq && memGrant) begin
      if (memWe) mem[memAddr] <= memWdata;
      else begin
        memRdata  <= mem[memAddr];
        memRvalid <= 1'b1;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [AW+63:0] expQ [$];
  int unsigned    expRdAddr = 0;
  logic           prevStall = 1'b0;
  logic [AW-1:0]  prevAddr = '0;
  logic           prevWe = 1'b0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: samples at negedge, the request that commits at the next edge
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check("R8", "held request", {memReq, memWe, 59'd0, memAddr},
              {1'b1, prevWe, 59'd0, prevAddr});
      end
      prevStall = memReq && !memGrant;
      prevAddr  = memAddr;
      prevWe    = memWe;
      if (memReq && memGrant && !memWe) begin
        check("R6", "read address order", 64'(memAddr), 64'(expRdAddr));
      end
      if (memReq && memGrant && memWe) begin
        if (expQ.size() == 0) begin
          check("R10", "unexpected write", 64'(memAddr), 64'hFFFF);
        end else begin
          logic [AW+63:0] item;
          item = expQ.pop_front();
          check("R6", "write address", 64'(memAddr), 64'(item[AW+63:64]));
          check("R7", "halved data", memWdata, item[63:0]);
          expRdAddr = (expRdAddr + 1) % WORDS;
        end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic loadPlane(logic [7:0] seed);
    loadSeed  = seed;
    loadPulse = 1'b1;
    @(negedge clk);
    loadPulse = 1'b0;
  endtask

  task automatic pushSweep(logic [7:0] seed);
    for (int i = 0; i < WORDS; i++) expQ.push_back({AW'(i), halve(pattern(i, seed))});
  endtask

  task automatic snoop(logic [63:0] d);
    snoopWrEn   = 1'b1;
    snoopWrData = d;
    @(negedge clk);
    snoopWrEn   = 1'b0;
    snoopWrData = '0;
  endtask

  task automatic pulseDone();
    accumDone = 1'b1;
    @(negedge clk);
    accumDone = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R9", "sweep ends", 64'(busy), 64'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", 64'(busy), 64'd0);
    check("R1", "flag after reset", 64'(exceedFlag), 64'd0);
    check("R1", "memReq after reset", 64'(memReq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Threshold 0xE0: equal does not set, 0xE1 in lane 3 does
    thrSel = 1'b0;
    snoop({8{8'hE0}});
    check("R2", "equal to 0xE0", 64'(exceedFlag), 64'd0);
    snoop(64'h0000_0000_E100_0000);
    check("R3", "0xE1 with thrSel=0", 64'(exceedFlag), 64'd1);
    snoop(64'h0);
    snoop(64'h1010_1010_1010_1010);
    check("R4", "flag sticky", 64'(exceedFlag), 64'd1);

    // Sweep under random grant
    loadPlane(8'h3C);
    pushSweep(8'h3C);
    pulseDone();
    check("R5", "busy after done", 64'(busy), 64'd1);
    waitIdle();
    check("R9", "flag cleared", 64'(exceedFlag), 64'd0);
    check("R6", "all words visited", 64'(expQ.size()), 64'd0);

    // Threshold 0xF0: 0xE5 and 0xF0 no, 0xF1 in lane 7 yes
    thrSel = 1'b1;
    snoop({8{8'hE5}});
    check("R3", "0xE5 with thrSel=1", 64'(exceedFlag), 64'd0);
    snoop({8{8'hF0}});
    check("R2", "equal to 0xF0", 64'(exceedFlag), 64'd0);
    snoop(64'hF100_0000_0000_0000);
    check("R3", "0xF1 lane 7", 64'(exceedFlag), 64'd1);

    // Sweep with disturbance while busy
    loadPlane(8'h5A);
    pushSweep(8'h5A);
    pulseDone();
    repeat (6) @(negedge clk);
    snoop({8{8'hFF}});
    pulseDone();
    repeat (5) @(negedge clk);
    snoop(64'hFF);
    waitIdle();
    check("R10", "flag after disturbed sweep", 64'(exceedFlag), 64'd0);
    repeat (20) @(negedge clk);
    check("R10", "no second sweep", 64'(busy), 64'd0);
    check("R10", "queue drained", 64'(expQ.size()), 64'd0);

    // Done without exceed: nothing happens
    pulseDone();
    check("R5", "no sweep without flag", 64'(busy), 64'd0);
    repeat (5) @(negedge clk);
    check("R5", "no request without flag", 64'(memReq), 64'd0);

    // Crossing in the same cycle as done, full grant
    fullGrant = 1'b1;
    thrSel    = 1'b0;
    loadPlane(8'hC3);
    pushSweep(8'hC3);
    snoopWrEn   = 1'b1;
    snoopWrData = 64'h0000_00F7_0000_0000;
    accumDone   = 1'b1;
    @(negedge clk);
    snoopWrEn   = 1'b0;
    accumDone   = 1'b0;
    check("R5", "same-cycle crossing starts sweep", 64'(busy), 64'd1);
    waitIdle();
    check("R9", "flag cleared after full-grant sweep", 64'(exceedFlag), 64'd0);
    check("R6", "all words visited again", 64'(expQ.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule